// File: doc/BRIEF.md
# Memory-Mapped BCD Real-Time Clock

This block is a calendar clock that occupies the top sixteen byte addresses of a 128K-byte asynchronous-SRAM-style address space. A 100 Hz tick input advances an internal chain of packed-BCD counters: hundredths, seconds, minutes, hours, weekday, date, month and two-digit year. Software never reads those counters directly. It sees a separate bank of window registers, and the counters copy their state into that bank each time a new second begins. Because the bank is separate, an access anywhere in the address space never waits on a clock update.

The window also holds alarm compare fields, interrupt enables, a periodic-interval select and a spare trim byte. A control byte holds two flags and two bits. A freeze bit stops the window from refreshing, so that software can read several bytes from the same instant. A hold bit stops the refresh in the same way, and when software clears it the counters are loaded from the window. Any address below the window turns on an external array-enable output. For those addresses the data bus is left undriven. While the power-fail input is high, the block is deselected.

Top module: `rtc_mmio`

## Requirements
- R1: The counters hold packed BCD. Hundredths wrap from 99 to 00 and carry into seconds. Seconds and minutes wrap from 59 to 00 and carry onward. Hours wrap from 23 to 00 and carry into the day.
- R2: A day carry advances the weekday from 7 back to 1. It also advances the date past the last day of the month: 30 days for months 04, 06, 09 and 11, 31 days for the other months, and for month 02, 29 days when the BCD year is a multiple of four and 28 otherwise. Month 12 wraps to 01, and year 99 wraps to 00.
- R3: Offsets 0 to 15 sit at addresses 1FFF0h to 1FFFFh. Offset 1 is hundredths, 2 seconds, 3 minutes, 4 hours, 5 weekday, 6 date, 7 month, 8 year, 9 to 12 alarm seconds, minutes, hours and date, 13 interrupt enables, 14 interval select, 15 spare byte. A read (chip enable low, output enable low, write enable high) inside the window drives data and raises the drive flag. Below the window, the array enable goes low, and data stays at 00 with the drive flag low.
- R4: When the tick sampled at a clock edge rolls hundredths from 99 to 00, the window time registers (offsets 1 to 8) take the new counter values at the next edge. Between such edges they change only through bus writes.
- R5: Offset 0 bit 7 (freeze) and bit 6 (hold) each block the refresh while set. The counters keep running.
- R6: A write to offset 0 that clears hold while it is set loads all counters from window offsets 1 to 8 at that edge. A tick sampled at the same edge is dropped.
- R7: On each second rollover, the alarm flag (offset 0 bit 0) sets if every alarm field whose bit 7 is 0 equals the new counter value for that field. A field with bit 7 set is ignored.
- R8: Offset 14 bits 2:0 select the periodic event. Code 1 fires on every tick, code 2 when hundredths reach a multiple of 10, code 3 at 00 and 50, and code 4 at 00. Any other code never fires. The event sets the periodic flag (offset 0 bit 1) one edge after the tick edge.
- R9: A read of offset 0 returns {freeze, hold, 0000, periodic flag, alarm flag}. It clears both flags at the end of the read cycle, unless a new event sets a flag at that same edge.
- R10: irq_no is low exactly when (alarm flag AND offset 13 bit 0) OR (periodic flag AND offset 13 bit 1).
- R11: While pf_i is high, writes have no effect, read data is not driven, and the array enable stays high.
- R12: After reset, the time is 00:00:00.00 on weekday 01, date 01, month 01, year 00. All other bytes and flags are zero, and irq_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 00 when not driven |
| rdata_oe_o | output | 1 | High while read data is driven |
| array_ce_no | output | 1 | Enable for the external array, active low |
| pf_i | input | 1 | Power-fail, high deselects |
| tick_i | input | 1 | One-cycle 100 Hz count pulse |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Read data, the drive flag and the array enable are combinational, so they are sampled in the same cycle as the address. A register write appears one edge later. A tick sampled at edge k changes the counters at edge k and changes the window, the flags and irq_no at edge k+1. A flag read clears the flags at the edge that closes the read cycle. The reference model advances on each edge and is compared 2 ns after each falling edge. Every directed check waits the number of edges listed above before it samples.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NREG  = 16;
  localparam int unsigned NTIME = 8;
  localparam int unsigned NALM  = 4;

  // hs occupies the low byte: byte i-1 maps to window offset i
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
    logic [7:0] hs;
  } rtc_time_t;

  localparam rtc_time_t RTC_EPOCH = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                      hr: 8'h00, min: 8'h00, sec: 8'h00, hs: 8'h00};

  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] last,
                                          input logic [7:0] first);
    if (v == last) return first;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    // (10*t + u) % 4 == 0  <=>  (2*t + u) % 4 == 0
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_chain.sv
module rtc_chain import rtc_pkg::*; #(
  parameter rtc_time_t RESET_TIME = RTC_EPOCH
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o,
  output logic      tick_o,
  output logic      sec_o
);
  rtc_time_t cnt_q, nxt;
  logic c_s, c_m, c_h, c_d, c_mo, c_y;
  logic [7:0] last_day;

  always_comb begin
    last_day = month_last(cnt_q.mon, cnt_q.yr);
    c_s  = cnt_q.hs == 8'h99;
    c_m  = c_s  && cnt_q.sec  == 8'h59;
    c_h  = c_m  && cnt_q.min  == 8'h59;
    c_d  = c_h  && cnt_q.hr   == 8'h23;
    c_mo = c_d  && cnt_q.date == last_day;
    c_y  = c_mo && cnt_q.mon  == 8'h12;
    nxt = cnt_q;
    nxt.hs = bcd_step(cnt_q.hs, 8'h99, 8'h00);
    if (c_s)  nxt.sec  = bcd_step(cnt_q.sec, 8'h59, 8'h00);
    if (c_m)  nxt.min  = bcd_step(cnt_q.min, 8'h59, 8'h00);
    if (c_h)  nxt.hr   = bcd_step(cnt_q.hr, 8'h23, 8'h00);
    if (c_d)  nxt.dow  = bcd_step(cnt_q.dow, 8'h07, 8'h01);
    if (c_d)  nxt.date = bcd_step(cnt_q.date, last_day, 8'h01);
    if (c_mo) nxt.mon  = bcd_step(cnt_q.mon, 8'h12, 8'h01);
    if (c_y)  nxt.yr   = bcd_step(cnt_q.yr, 8'h99, 8'h00);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RESET_TIME;
      tick_o <= 1'b0;
      sec_o  <= 1'b0;
    end else begin
      tick_o <= tick_i && !load_i;
      sec_o  <= tick_i && !load_i && c_s;
      if (load_i)      cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= nxt;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_event.sv
module rtc_event import rtc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sec_i,
  input  logic [7:0] hs_i,
  input  logic [7:0] cur_i [NALM],
  input  logic [7:0] alm_i [NALM],
  input  logic [2:0] rate_i,
  input  logic       clr_i,
  output logic       alarm_flag_o,
  output logic       per_flag_o
);
  logic [NALM-1:0] hit;
  logic per_hit;

  for (genvar i = 0; i < NALM; i++) begin : g_cmp
    assign hit[i] = alm_i[i][7] || ({1'b0, alm_i[i][6:0]} == cur_i[i]);
  end

  always_comb begin
    case (rate_i)
      3'd1:    per_hit = 1'b1;
      3'd2:    per_hit = hs_i[3:0] == 4'd0;
      3'd3:    per_hit = hs_i[3:0] == 4'd0 && (hs_i[7:4] == 4'd0 || hs_i[7:4] == 4'd5);
      3'd4:    per_hit = hs_i == 8'h00;
      default: per_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_flag_o <= 1'b0;
      per_flag_o   <= 1'b0;
    end else begin
      alarm_flag_o <= (sec_i && &hit) || (alarm_flag_o && !clr_i);
      per_flag_o   <= (tick_i && per_hit) || (per_flag_o && !clr_i);
    end
  end
endmodule

// File: rtl/rtc_mmio.sv
module rtc_mmio import rtc_pkg::*; #(
  parameter int unsigned ADDR_W     = 17,
  parameter rtc_time_t   RESET_TIME = RTC_EPOCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rdata_oe_o,
  output logic              array_ce_no,
  input  logic              pf_i,
  input  logic              tick_i,
  output logic              irq_no
);
  localparam int unsigned OFF_W = $clog2(NREG);
  localparam int unsigned O_ALM = NTIME + 1;
  localparam int unsigned O_IEN = O_ALM + NALM;
  localparam int unsigned O_RATE = O_IEN + 1;

  logic [OFF_W-1:0] off;
  logic in_win, sel, wr_en, rd_en, load, refresh, clr;
  logic frz_q, hold_q;
  logic [7:0] regs_q [1:NREG-1];
  logic [7:0] rd_val;
  rtc_time_t cnt, load_val;
  logic tick_q, sec_q, alarm_flag, per_flag;
  logic [7:0] cur [NALM];
  logic [7:0] alm [NALM];

  assign off     = addr_i[OFF_W-1:0];
  assign in_win  = &addr_i[ADDR_W-1:OFF_W];
  assign sel     = !ce_ni && !pf_i;
  assign wr_en   = sel && !we_ni && in_win;
  assign rd_en   = sel && !oe_ni && we_ni && in_win;
  assign load    = wr_en && off == '0 && hold_q && !wdata_i[6];
  assign refresh = sec_q && !frz_q && !hold_q;
  assign clr     = rd_en && off == '0;
  assign array_ce_no = !(sel && !in_win);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (wr_en && off == '0) begin
      frz_q  <= wdata_i[7];
      hold_q <= wdata_i[6];
    end
  end

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [7:0] rst_v, upd_v;
    logic upd;
    if (i <= NTIME) begin : g_time
      assign rst_v = RESET_TIME[8*(i-1) +: 8];
      assign upd_v = cnt[8*(i-1) +: 8];
      assign upd   = refresh;
      assign load_val[8*(i-1) +: 8] = regs_q[i];
    end else begin : g_plain
      assign rst_v = '0;
      assign upd_v = '0;
      assign upd   = 1'b0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[i] <= rst_v;
      else if (wr_en && off == OFF_W'(i))     regs_q[i] <= wdata_i;
      else if (upd)                           regs_q[i] <= upd_v;
    end
  end

  always_comb begin
    rd_val = {frz_q, hold_q, 4'b0000, per_flag, alarm_flag};
    for (int k = 1; k < NREG; k++) if (off == OFF_W'(k)) rd_val = regs_q[k];
  end

  assign rdata_o    = rd_en ? rd_val : 8'h00;
  assign rdata_oe_o = rd_en;

  rtc_chain #(.RESET_TIME(RESET_TIME)) u_chain (
    .clk_i, .rst_ni, .tick_i, .load_i(load), .load_val_i(load_val),
    .cnt_o(cnt), .tick_o(tick_q), .sec_o(sec_q)
  );

  assign cur[0] = cnt.sec;
  assign cur[1] = cnt.min;
  assign cur[2] = cnt.hr;
  assign cur[3] = cnt.date;
  for (genvar j = 0; j < NALM; j++) begin : g_alm
    assign alm[j] = regs_q[O_ALM + j];
  end

  rtc_event u_event (
    .clk_i, .rst_ni, .tick_i(tick_q), .sec_i(sec_q), .hs_i(cnt.hs),
    .cur_i(cur), .alm_i(alm), .rate_i(regs_q[O_RATE][2:0]), .clr_i(clr),
    .alarm_flag_o(alarm_flag), .per_flag_o(per_flag)
  );

  assign irq_no = !((alarm_flag && regs_q[O_IEN][0]) || (per_flag && regs_q[O_IEN][1]));
endmodule

// File: rtl/rtc_mmio_chk.sv
module rtc_mmio_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pf_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rdata_oe_o,
  input logic              array_ce_no,
  input logic              irq_no,
  input logic              alarm_flag_i,
  input logic              per_flag_i,
  input logic              sec_pulse_i,
  input logic              wr_en_i,
  input logic [7:0]        vis_sec_i
);
  a_r3_drive_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> &addr_i[ADDR_W-1:4]);
  a_r3_array_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !array_ce_no |-> !rdata_oe_o);
  a_r11_pf_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_i |-> (array_ce_no && !rdata_oe_o));
  a_r10_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (alarm_flag_i || per_flag_i));
  a_r4_refresh_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vis_sec_i) |-> $past(sec_pulse_i || wr_en_i));
  a_r7_alarm_on_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag_i) |-> $past(sec_pulse_i));
endmodule

bind rtc_mmio rtc_mmio_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pf_i(pf_i), .addr_i(addr_i),
  .rdata_oe_o(rdata_oe_o), .array_ce_no(array_ce_no), .irq_no(irq_no),
  .alarm_flag_i(alarm_flag), .per_flag_i(per_flag), .sec_pulse_i(sec_q),
  .wr_en_i(wr_en), .vis_sec_i(regs_q[2])
);

// File: tb/tb_rtc_mmio.sv
module tb_rtc_mmio;
  localparam logic [16:0] WIN = 17'h1FFF0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pf = 1'b0, tick = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe, array_ce_n, irq_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string phase = "R12";

  always #5 clk = ~clk;

  rtc_mmio dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
    .array_ce_no(array_ce_n), .pf_i(pf), .tick_i(tick), .irq_no(irq_n)
  );

  // ---------------- reference model ----------------
  int m_t [8];               // hs, sec, min, hr, dow, date, mon, yr (binary)
  logic [7:0] m_reg [16];
  bit m_frz, m_hold, m_af, m_pf, m_tickp, m_secp;

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int bin(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic bit m_win();
    return addr[16:4] == WIN[16:4];
  endfunction
  function automatic bit m_rd();
    return !ce_n && !oe_n && we_n && !pf && m_win();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = '{0, 0, 0, 0, 1, 1, 1, 0};
      for (int k = 0; k < 16; k++) m_reg[k] = 8'h00;
      for (int k = 0; k < 8; k++) m_reg[k+1] = bcd(m_t[k]);
      {m_frz, m_hold, m_af, m_pf, m_tickp, m_secp} = '0;
    end else begin
      bit wr, rd, ld, ahit, phit, refr, n_af, n_pf;
      int off, old_t [8], cur [4];
      logic [7:0] a;
      wr  = !ce_n && !we_n && !pf && m_win();
      rd  = m_rd();
      off = int'(addr[3:0]);
      ld  = wr && off == 0 && m_hold && !wdata[6];
      cur = '{m_t[1], m_t[2], m_t[3], m_t[5]};
      ahit = 1'b1;
      for (int k = 0; k < 4; k++) begin
        a = m_reg[9+k];
        if (!a[7] && a != bcd(cur[k])) ahit = 1'b0;
      end
      case (m_reg[14][2:0])
        3'd1: phit = 1'b1;
        3'd2: phit = m_t[0] % 10 == 0;
        3'd3: phit = m_t[0] % 50 == 0;
        3'd4: phit = m_t[0] == 0;
        default: phit = 1'b0;
      endcase
      n_af = (m_secp && ahit) || (m_af && !(rd && off == 0));
      n_pf = (m_tickp && phit) || (m_pf && !(rd && off == 0));
      refr = m_secp && !m_frz && !m_hold;
      old_t = m_t;
      m_secp  = tick && !ld && m_t[0] == 99;
      m_tickp = tick && !ld;
      if (ld) begin
        for (int k = 0; k < 8; k++) m_t[k] = bin(m_reg[k+1]);
      end else if (tick) begin
        m_t[0]++;
        if (m_t[0] == 100) begin
          m_t[0] = 0; m_t[1]++;
          if (m_t[1] == 60) begin
            m_t[1] = 0; m_t[2]++;
            if (m_t[2] == 60) begin
              m_t[2] = 0; m_t[3]++;
              if (m_t[3] == 24) begin
                m_t[3] = 0;
                m_t[4] = (m_t[4] == 7) ? 1 : m_t[4] + 1;
                m_t[5]++;
                if (m_t[5] > dim(m_t[6], m_t[7])) begin
                  m_t[5] = 1; m_t[6]++;
                  if (m_t[6] == 13) begin
                    m_t[6] = 1; m_t[7] = (m_t[7] + 1) % 100;
                  end
                end
              end
            end
          end
        end
      end
      if (refr) for (int k = 0; k < 8; k++) m_reg[k+1] = bcd(old_t[k]);
      if (wr) begin
        if (off == 0) begin
          m_frz = wdata[7]; m_hold = wdata[6];
        end else m_reg[off] = wdata;
      end
      m_af = n_af; m_pf = n_pf;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after each falling edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      logic [7:0] e_rd;
      e_rd = 8'h00;
      if (m_rd()) e_rd = (addr[3:0] == 4'd0) ? {m_frz, m_hold, 4'b0000, m_pf, m_af}
                                             : m_reg[addr[3:0]];
      chk({phase, " rdata"}, rdata, e_rd);
      chk({phase, " rdata_oe"}, {7'd0, rdata_oe}, {7'd0, m_rd()});
      chk({phase, " array_ce_n"}, {7'd0, array_ce_n}, {7'd0, !(!ce_n && !pf && !m_win())});
      chk({phase, " irq_n"}, {7'd0, irq_n},
          {7'd0, !((m_af && m_reg[13][0]) || (m_pf && m_reg[13][1]))});
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask
  task automatic wr(int off, logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = WIN | 17'(off); wdata = d;
    @(negedge clk);
    idle();
  endtask
  task automatic rd_chk(int off, logic [7:0] exp, string tag);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = WIN | 17'(off);
    #2 chk(tag, rdata, exp);
    @(negedge clk);
    idle();
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask
  task automatic settle();
    @(negedge clk);
  endtask
  task automatic set_time(logic [7:0] t [8]);
    wr(0, 8'h40);
    for (int k = 0; k < 8; k++) wr(k + 1, t[k]);
    wr(0, 8'h00);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    phase = "R12";
    rd_chk(2, 8'h00, "R12 sec");
    rd_chk(5, 8'h01, "R12 dow");
    rd_chk(6, 8'h01, "R12 date");
    rd_chk(8, 8'h00, "R12 year");
    rd_chk(0, 8'h00, "R12 ctrl");
    chk("R12 irq_n", {7'd0, irq_n}, 8'h01);

    // R3 below window goes to the array
    phase = "R3";
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = 17'h00010;
    #2 chk("R3 array_ce_n low", {7'd0, array_ce_n}, 8'h00);
    chk("R3 no drive below", {7'd0, rdata_oe}, 8'h00);
    @(negedge clk); idle();
    wr(15, 8'h5A);
    rd_chk(15, 8'h5A, "R3 spare byte");

    // R1 R2 R6 leap day, weekday wrap
    phase = "R2";
    set_time('{8'h98, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24});
    ticks(2); settle();
    rd_chk(6, 8'h29, "R2 leap Feb 29");
    rd_chk(5, 8'h01, "R2 dow 7->1");
    rd_chk(4, 8'h00, "R1 hour 23->00");
    rd_chk(3, 8'h00, "R1 min 59->00");
    rd_chk(2, 8'h00, "R6 loaded then R1 sec 59->00");
    // R2 common year
    set_time('{8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23});
    ticks(1); settle();
    rd_chk(7, 8'h03, "R2 Feb->Mar month");
    rd_chk(6, 8'h01, "R2 Feb 28 -> 01");
    // R2 30-day month and year wrap
    set_time('{8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10});
    ticks(1); settle();
    rd_chk(7, 8'h05, "R2 Apr 30 -> May");
    set_time('{8'h99, 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99});
    ticks(1); settle();
    rd_chk(8, 8'h00, "R2 year 99->00");
    rd_chk(7, 8'h01, "R2 month 12->01");

    // R4 R5 freeze
    phase = "R5";
    set_time('{8'h00, 8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    wr(0, 8'h80);
    ticks(100); settle();
    rd_chk(2, 8'h10, "R5 frozen seconds");
    wr(0, 8'h00);
    phase = "R4";
    ticks(99); settle();
    rd_chk(2, 8'h10, "R4 no refresh before rollover");
    ticks(1); settle();
    rd_chk(2, 8'h12, "R4 refresh on rollover");

    // R7 alarm match and R9 clear
    phase = "R7";
    wr(13, 8'h01);
    wr(9, 8'h05); wr(10, 8'h80); wr(11, 8'h80); wr(12, 8'h80);
    set_time('{8'h99, 8'h04, 8'h30, 8'h12, 8'h01, 8'h01, 8'h01, 8'h00});
    ticks(1);
    settle(); #2 chk("R7 R10 irq on alarm", {7'd0, irq_n}, 8'h00);
    phase = "R9";
    rd_chk(0, 8'h01, "R9 alarm flag read");
    #2 chk("R9 irq released after read", {7'd0, irq_n}, 8'h01);
    rd_chk(0, 8'h00, "R9 flag cleared");
    phase = "R7";
    wr(9, 8'h07); wr(10, 8'h31);
    set_time('{8'h99, 8'h06, 8'h30, 8'h12, 8'h01, 8'h01, 8'h01, 8'h00});
    ticks(1); settle();
    rd_chk(0, 8'h00, "R7 minute mismatch no alarm");

    // R8 periodic 100 ms
    phase = "R8";
    wr(13, 8'h02); wr(14, 8'h02);
    set_time('{8'h08, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    ticks(1); settle();
    #2 chk("R8 no event at hs 09", {7'd0, irq_n}, 8'h01);
    ticks(1); settle();
    #2 chk("R8 event at hs 10", {7'd0, irq_n}, 8'h00);
    rd_chk(0, 8'h02, "R8 periodic flag");
    // R10 enable gating
    phase = "R10";
    wr(13, 8'h00); wr(14, 8'h01);
    ticks(1); settle();
    #2 chk("R10 masked irq", {7'd0, irq_n}, 8'h01);
    rd_chk(0, 8'h02, "R10 flag still set");
    wr(14, 8'h00);

    // R11 power fail
    phase = "R11";
    @(negedge clk); pf = 1'b1;
    ce_n = 1'b0; we_n = 1'b0; addr = WIN | 17'hF; wdata = 8'hC3;
    #2 chk("R11 array off", {7'd0, array_ce_n}, 8'h01);
    @(negedge clk); we_n = 1'b1; oe_n = 1'b0;
    #2 chk("R11 no drive", {7'd0, rdata_oe}, 8'h00);
    @(negedge clk); addr = 17'h00100;
    #2 chk("R11 array off low addr", {7'd0, array_ce_n}, 8'h01);
    @(negedge clk); idle(); pf = 1'b0;
    rd_chk(15, 8'h5A, "R11 write ignored");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule